// File: doc/BRIEF.md
# Line-Code Violation Monitor

This block watches the two receive rails of a bipolar line (one rail pulses for positive marks, the other for negative marks), one sample per receive clock. It tracks the polarity of the most recent mark and the polarity of the most recent bipolar violation. From these it decides, for every incoming mark, whether the mark is a plain bipolar violation, a legitimate zero-substitution violation, or a code violation. A code violation is two successive violations of the same polarity.

The result is a single registered flag. Three static controls decide which classes reach the flag: a decoder-enable, a unipolar-mode flag and a code-violation-detect enable. Plain violations are reported only when the decoder is off or unipolar mode is on. Code violations are reported whenever their enable is set, and they share the flag with plain reports.

The rails carry a continuous line sample with no flow control. They are consumed every clock, there is no back-pressure, and the output cannot stall. The controls are plain level inputs.

Top module: `hdb_viol_monitor`

## Requirements
- R1: An active-low reset forces the flag low and clears both polarity trackers, so the first mark after reset is never flagged and the first violation after reset is never a code violation.
- R2: A single-rail mark (rx_pos=1, rx_neg=0 is positive; rx_pos=0, rx_neg=1 is negative) whose polarity equals the previous mark's is a bipolar violation. Every single-rail mark, violating or not, becomes the new previous-mark polarity.
- R3: When decode_en=0 or unipolar_en=1, every bipolar violation raises the flag.
- R4: With decode_en=1 and unipolar_en=0, a bipolar violation whose polarity differs from the previous violation's (or that is the first since reset) is a valid substitution and does not raise the flag.
- R5: A bipolar violation with the same polarity as the previous violation is a code violation. It raises the flag whenever cv_detect_en=1, in any mode. With cv_detect_en=0 it is reported only through R3.
- R6: Every single-rail bipolar violation updates the last-violation polarity, whether or not anything is reported.
- R7: A cycle with both rails high is one violation event. It raises the flag when R3 reporting is active, and it leaves both trackers unchanged.
- R8: The flag reflects the rails sampled at a rising clock edge and is high for exactly the following clock cycle. Events on consecutive edges give a flag that stays high over consecutive cycles.
- R9: A cycle with both rails low causes no report and leaves both trackers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; rails sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pos | input | 1 | Positive-mark rail |
| rx_neg | input | 1 | Negative-mark rail |
| decode_en | input | 1 | Line decoder enabled; suppresses plain violation reports unless unipolar |
| unipolar_en | input | 1 | Unipolar mode; forces plain violation reporting |
| cv_detect_en | input | 1 | Enables code-violation reporting |
| viol_flag | output | 1 | One-cycle violation indicator |

## Verification
A corrupted previous-mark tracker becomes visible at the next single-rail mark. A wrongly classified mark either produces a spurious one-cycle flag or loses one, one cycle after that mark is sampled. A corrupted last-violation tracker stays hidden until the next violation, and it only shows when code-violation reporting is enabled and substitution reporting is suppressed. The bench therefore runs directed sequences that alternate violation polarity across mode changes. It also compares against a behavioural model on every cycle under random rails and random control settings.

// File: rtl/hdbv_pkg.sv
package hdbv_pkg;

  typedef enum logic [1:0] {
    POL_NONE = 2'b00,
    POL_POS  = 2'b01,
    POL_NEG  = 2'b10
  } pol_t;

  typedef struct packed {
    logic single;  // exactly one rail high
    logic both;    // both rails high
    pol_t pol;     // polarity of a single-rail mark
  } mark_t;

endpackage

// File: rtl/hdbv_classify.sv
module hdbv_classify
  import hdbv_pkg::*;
(
  input  logic  rail_p,
  input  logic  rail_n,
  output mark_t mark
);

  always_comb begin
    mark.single = rail_p ^ rail_n;
    mark.both   = rail_p & rail_n;
    if (rail_p && !rail_n)
      mark.pol = POL_POS;
    else if (rail_n && !rail_p)
      mark.pol = POL_NEG;
    else
      mark.pol = POL_NONE;
  end

endmodule

// File: rtl/hdbv_tracker.sv
module hdbv_tracker
  import hdbv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mark_t mark,
  output logic  bpv,
  output logic  codev
);

  pol_t last_mark_q;
  pol_t last_viol_q;

  always_comb begin
    bpv   = mark.single && (last_mark_q != POL_NONE) && (last_mark_q == mark.pol);
    codev = bpv && (last_viol_q == mark.pol);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_mark_q <= POL_NONE;
      last_viol_q <= POL_NONE;
    end else begin
      if (mark.single)
        last_mark_q <= mark.pol;
      if (bpv)
        last_viol_q <= mark.pol;
    end
  end

  // R1: reset leaves both trackers empty
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (last_mark_q == POL_NONE && last_viol_q == POL_NONE));

  // R2: a single-rail mark becomes the previous mark
  a_r2_mark_tracked: assert property (@(posedge clk) disable iff (!rst_n)
    mark.single |=> (last_mark_q == $past(mark.pol)));

  // R6: a violation sets the last-violation polarity
  a_r6_viol_tracked: assert property (@(posedge clk) disable iff (!rst_n)
    bpv |=> (last_viol_q == $past(mark.pol)));

  // R7: a both-rail cycle leaves the trackers alone
  a_r7_both_holds: assert property (@(posedge clk) disable iff (!rst_n)
    mark.both |=> ($stable(last_mark_q) && $stable(last_viol_q)));

  // R9: an idle cycle leaves the trackers alone
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!mark.single && !mark.both) |=> ($stable(last_mark_q) && $stable(last_viol_q)));

endmodule

// File: rtl/hdbv_report.sv
module hdbv_report (
  input  logic clk,
  input  logic rst_n,
  input  logic bpv,
  input  logic codev,
  input  logic both_ev,
  input  logic decode_en,
  input  logic unipolar_en,
  input  logic cv_detect_en,
  output logic flag
);

  logic plain_en;
  logic hit;
  logic flag_q;

  always_comb begin
    plain_en = !decode_en || unipolar_en;
    hit      = (plain_en && (bpv || both_ev)) || (cv_detect_en && codev);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else
      flag_q <= hit;
  end

  assign flag = flag_q;

  // R3: plain reporting flags every violation one cycle later
  a_r3_plain_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_en && bpv) |=> flag_q);

  // R4: substitution violations stay silent with the decoder active
  a_r4_sub_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bpv && !codev && !plain_en) |=> !flag_q);

  // R5: code violations reach the flag when enabled
  a_r5_codev_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_detect_en && codev) |=> flag_q);

  // R8: no event, no flag in the next cycle
  a_r8_no_event_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!bpv && !both_ev) |=> !flag_q);

endmodule

// File: rtl/hdb_viol_monitor.sv
module hdb_viol_monitor
  import hdbv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pos,
  input  logic rx_neg,
  input  logic decode_en,
  input  logic unipolar_en,
  input  logic cv_detect_en,
  output logic viol_flag
);

  mark_t mark;
  logic  bpv;
  logic  codev;

  hdbv_classify u_classify (
    .rail_p (rx_pos),
    .rail_n (rx_neg),
    .mark   (mark)
  );

  hdbv_tracker u_tracker (
    .clk   (clk),
    .rst_n (rst_n),
    .mark  (mark),
    .bpv   (bpv),
    .codev (codev)
  );

  hdbv_report u_report (
    .clk          (clk),
    .rst_n        (rst_n),
    .bpv          (bpv),
    .codev        (codev),
    .both_ev      (mark.both),
    .decode_en    (decode_en),
    .unipolar_en  (unipolar_en),
    .cv_detect_en (cv_detect_en),
    .flag         (viol_flag)
  );

  // R8: idle rails never produce a flag in the next cycle
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_pos && !rx_neg) |=> !viol_flag);

  // R2: an alternating mark is never a violation
  a_r2_alternate_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pos ^ rx_neg) && !bpv |=> !viol_flag);

endmodule

// File: tb/test_hdb_viol_monitor.sv
module test_hdb_viol_monitor;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_pos = 1'b0, rx_neg = 1'b0;
  logic decode_en = 1'b0, unipolar_en = 1'b0, cv_detect_en = 1'b0;
  logic viol_flag;

  int checks = 0;
  int fails = 0;
  int lm = 0;         // previous mark: 0 none, 1 positive, -1 negative
  int lv = 0;         // previous violation polarity
  logic exp_q = 1'b0;
  string tag_q = "R1";

  always #2 clk = ~clk;

  hdb_viol_monitor i_hdb_viol_monitor (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_pos       (rx_pos),
    .rx_neg       (rx_neg),
    .decode_en    (decode_en),
    .unipolar_en  (unipolar_en),
    .cv_detect_en (cv_detect_en),
    .viol_flag    (viol_flag)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // check the pending expectation, then apply new stimulus and predict it
  task automatic step(input logic p, input logic n, input logic de,
                      input logic un, input logic cv, input string ovr);
    logic plain;
    logic rep;
    int pol;
    bit is_bpv;
    bit is_cod;
    string t;
    @(negedge clk);
    check(viol_flag, exp_q, tag_q);
    rx_pos = p; rx_neg = n;
    decode_en = de; unipolar_en = un; cv_detect_en = cv;
    plain = !de || un;
    if (p && n) begin
      rep = plain;
      t = "R7";
    end else if (p || n) begin
      pol = p ? 1 : -1;
      is_bpv = (lm == pol);
      is_cod = 1'b0;
      lm = pol;
      if (is_bpv) begin
        is_cod = (lv == pol);
        lv = pol;
      end
      rep = (plain && is_bpv) || (cv && is_cod);
      t = is_cod ? "R5" : (is_bpv ? (plain ? "R3" : "R4") : "R2");
    end else begin
      rep = 1'b0;
      t = "R9";
    end
    exp_q = rep;
    tag_q = (ovr != "") ? ovr : t;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rx_pos = 1'b0; rx_neg = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check(viol_flag, 1'b0, "R1");
    end
    @(negedge clk);
    rst_n = 1'b1;
    lm = 0; lv = 0;
    exp_q = 1'b0;
    tag_q = "R1";
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R8 watchdog actual=hang expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // plain reporting, decoder off (R2, R3)
    step(1,0, 0,0,0, ""); step(0,1, 0,0,0, ""); step(1,0, 0,0,0, "");
    step(1,0, 0,0,0, ""); step(0,1, 0,0,0, ""); step(0,1, 0,0,0, "");
    // back-to-back violations, flag stays high (R8)
    step(1,0, 0,0,0, "R8"); step(1,0, 0,0,0, "R8"); step(1,0, 0,0,0, "R8");
    step(0,0, 0,0,0, "R8");
    // first mark after reset is clean (R1)
    step(1,0, 0,0,0, "");
    do_reset();
    step(1,0, 0,0,0, "R1"); step(0,0, 0,0,0, "");
    // decoder on: substitutions quiet, code violation flagged (R4, R5)
    do_reset();
    step(1,0, 1,0,1, ""); step(1,0, 1,0,1, ""); step(0,1, 1,0,1, "");
    step(0,1, 1,0,1, ""); step(1,0, 1,0,1, ""); step(1,0, 1,0,1, "");
    step(1,0, 1,0,1, "");
    // code violation with detection off (R5)
    step(1,0, 1,0,0, "");
    // unipolar forces plain reporting (R3)
    step(0,1, 1,1,0, ""); step(0,1, 1,1,0, "");
    // both rails (R7)
    step(1,0, 0,0,0, ""); step(1,1, 0,0,0, ""); step(1,0, 0,0,0, "R7");
    step(1,1, 1,0,0, ""); step(0,0, 1,0,0, "");
    // last violation updated while unreported (R6)
    do_reset();
    step(1,0, 1,0,0, ""); step(1,0, 1,0,0, "R6"); step(0,1, 1,0,1, "");
    step(1,0, 1,0,1, ""); step(1,0, 1,0,1, "R6");
    // idle gaps keep trackers (R9)
    step(0,0, 0,0,0, ""); step(0,0, 0,0,0, ""); step(1,0, 0,0,0, "R9");
    step(0,0, 0,0,0, "");
    // random traffic with random controls
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic de, un, cv;
      r = $urandom_range(0, 9);
      if (i % 64 == 0) begin
        de = 1'($urandom_range(0, 1));
        un = 1'($urandom_range(0, 1));
        cv = 1'($urandom_range(0, 1));
      end else begin
        de = decode_en; un = unipolar_en; cv = cv_detect_en;
      end
      if (r < 4)       step(1,0, de,un,cv, "");
      else if (r < 8)  step(0,1, de,un,cv, "");
      else if (r == 8) step(0,0, de,un,cv, "");
      else             step(1,1, de,un,cv, "");
    end
    step(0,0, 0,0,0, "");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule